// File: doc/BRIEF.md
# Nearest-Template Binary Classifier

The block keeps a small bank of binary template vectors, each tagged with a class number, and answers one question about an incoming binary query. The question is which class owns the stored template that lies closest to the query in Hamming distance. During training, software-free logic upstream writes feature vectors into template rows through a write port. A class may own a single row (one-shot use) or several rows (few-shot use). During inference, a query is presented on the search port together with a start strobe.

A search runs as a fixed sequence of one-clock phases. The precharge phase captures the query. The search phase counts, for every row, the bit positions where row and query disagree. The evaluate phase passes those counts through a minimum-finding tree. The winning class, its distance and a found flag are registered, and a one-cycle done pulse follows. Rows marked invalid take no part in the search. Among equal distances, the lowest row index is chosen. Writes that arrive while a search is running are held until the search ends, so every search sees one consistent template set.

Top module: `hdc_classifier`

## Requirements
- R1: The bank holds 25 rows, each with a 128-bit template, a 3-bit class tag and a valid flag, all loaded by one write (wr_en with wr_row, wr_data, wr_class, wr_valid); a write with wr_row of 25 or above changes nothing; after reset every row is invalid.
- R2: The distance of a row is the number of bit positions where its template and the query differ, a value from 0 to 128, reported on the 8-bit res_dist.
- R3: After a search, res_class is the class tag of the valid row with the smallest distance, res_dist is that distance and res_found is 1; several rows may share one class tag.
- R4: When several valid rows share the smallest distance, the row with the lowest index decides res_class.
- R5: Invalid rows are excluded from the minimum; if no row is valid, the search reports res_found 0, res_class 0 and res_dist 0.
- R6: A valid row equal to the query gives distance 0 and wins over every row with a nonzero distance.
- R7: A start seen at a clock edge while busy is 0 is accepted; busy is then 1 for exactly three cycles (precharge, search, evaluate), and done is 1 for exactly one cycle right after them, in the same cycle that busy returns to 0 and the new results appear.
- R8: A start seen while busy is 1 is ignored: it produces no extra busy cycle and no extra done pulse.
- R9: A write issued while busy is 1 does not affect the running search; it is held (a later held write replaces an earlier one) and applied at the first clock edge with busy 0, so the next search sees it.
- R10: res_found, res_class and res_dist change only at the edge that raises done and hold their values between searches.
- R11: After reset busy, done, res_found, res_class and res_dist are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Template write strobe |
| wr_row | input | 5 | Row index to write |
| wr_class | input | 3 | Class tag for the written row |
| wr_valid | input | 1 | Valid flag for the written row |
| wr_data | input | 128 | Template vector |
| start | input | 1 | Search start strobe |
| query | input | 128 | Query vector, sampled with an accepted start |
| busy | output | 1 | Search sequence in progress |
| done | output | 1 | One-cycle pulse when results are new |
| res_found | output | 1 | At least one valid row took part |
| res_class | output | 3 | Class of the nearest row |
| res_dist | output | 8 | Hamming distance of the nearest row |

## Verification
The hardest situation to reach from the ports is a write that lands in the middle of a search to a row that would have won it, because it must be invisible to that search yet decide the next one. The stimulus starts a search, issues during the busy window a write that copies the query into a low row, checks that the running search still reports the old winner, and then repeats the query to see distance 0 from the held row. Ties and exclusion are reached by writing identical templates into rows of different classes and by clearing rows, while constrained-random queries are made by flipping a few bits of a stored template so that distances cluster near the minimum.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_SRCH = 2'd2,
    PH_EVAL = 2'd3
  } phase_e;
endpackage

// File: rtl/hdc_template_bank.sv
module hdc_template_bank #(
  parameter int VEC_W   = 128,
  parameter int ROWS    = 25,
  parameter int CLASS_W = 3,
  parameter int ROW_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic               wr_en,
  input  logic [ROW_W-1:0]   wr_row,
  input  logic [CLASS_W-1:0] wr_class,
  input  logic               wr_valid,
  input  logic [VEC_W-1:0]   wr_data,
  output logic [VEC_W-1:0]   row_data  [ROWS],
  output logic [CLASS_W-1:0] row_class [ROWS],
  output logic               row_valid [ROWS]
);
  localparam logic [ROW_W:0] ROW_LIMIT = (ROW_W+1)'(ROWS);

  logic               wr_in_range;
  logic               pend_v_q, pend_v_d;
  logic [ROW_W-1:0]   pend_row_q, pend_row_d;
  logic [CLASS_W-1:0] pend_cls_q, pend_cls_d;
  logic               pend_vld_q, pend_vld_d;
  logic [VEC_W-1:0]   pend_dat_q, pend_dat_d;
  logic               pend_en;

  assign wr_in_range = ({1'b0, wr_row} < ROW_LIMIT);

  // Pending slot: captures a write issued while a search is running.
  always_comb begin
    pend_v_d   = pend_v_q;
    pend_row_d = pend_row_q;
    pend_cls_d = pend_cls_q;
    pend_vld_d = pend_vld_q;
    pend_dat_d = pend_dat_q;
    pend_en    = 1'b0;
    if (hold) begin
      if (wr_en && wr_in_range) begin
        pend_v_d   = 1'b1;
        pend_row_d = wr_row;
        pend_cls_d = wr_class;
        pend_vld_d = wr_valid;
        pend_dat_d = wr_data;
        pend_en    = 1'b1;
      end
    end else if (pend_v_q) begin
      pend_v_d = 1'b0;
      pend_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q   <= 1'b0;
      pend_row_q <= '0;
      pend_cls_q <= '0;
      pend_vld_q <= 1'b0;
    end else if (pend_en) begin
      pend_v_q   <= pend_v_d;
      pend_row_q <= pend_row_d;
      pend_cls_q <= pend_cls_d;
      pend_vld_q <= pend_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_en) pend_dat_q <= pend_dat_d;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic               take_dir, take_pend, row_en;
    logic [VEC_W-1:0]   dat_d;
    logic [CLASS_W-1:0] cls_d;
    logic               vld_d;

    // A direct write in the same idle cycle overrides the held one.
    always_comb begin
      take_dir  = !hold && wr_en && (wr_row == ROW_W'(r));
      take_pend = !hold && pend_v_q && (pend_row_q == ROW_W'(r));
      row_en    = take_dir || take_pend;
      dat_d     = take_dir ? wr_data  : pend_dat_q;
      cls_d     = take_dir ? wr_class : pend_cls_q;
      vld_d     = take_dir ? wr_valid : pend_vld_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_valid[r] <= 1'b0;
        row_class[r] <= '0;
      end else if (row_en) begin
        row_valid[r] <= vld_d;
        row_class[r] <= cls_d;
      end
    end

    always_ff @(posedge clk) begin
      if (row_en) row_data[r] <= dat_d;
    end
  end
endmodule

// File: rtl/hdc_dist_array.sv
module hdc_dist_array #(
  parameter int VEC_W  = 128,
  parameter int ROWS   = 25,
  parameter int DIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [VEC_W-1:0]  query_vec,
  input  logic [VEC_W-1:0]  row_data [ROWS],
  output logic [DIST_W-1:0] row_dist [ROWS]
);
  function automatic logic [DIST_W-1:0] count_ones(input logic [VEC_W-1:0] v);
    logic [DIST_W-1:0] acc;
    acc = '0;
    for (int b = 0; b < VEC_W; b++) acc = acc + DIST_W'(v[b]);
    return acc;
  endfunction

  for (genvar r = 0; r < ROWS; r++) begin : g_cnt
    logic [DIST_W-1:0] dist_d;

    always_comb dist_d = count_ones(row_data[r] ^ query_vec);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       row_dist[r] <= '0;
      else if (load_en) row_dist[r] <= dist_d;
    end
  end
endmodule

// File: rtl/hdc_argmin_tree.sv
module hdc_argmin_tree #(
  parameter int ROWS   = 25,
  parameter int DIST_W = 8,
  parameter int ROW_W  = 5
) (
  input  logic              row_valid [ROWS],
  input  logic [DIST_W-1:0] row_dist  [ROWS],
  output logic              win_found,
  output logic [DIST_W-1:0] win_dist,
  output logic [ROW_W-1:0]  win_idx
);
  localparam int LEAVES = 1 << ROW_W;
  localparam int NODES  = 2 * LEAVES - 1;
  localparam int FIRST  = LEAVES - 1;

  logic              nd_f [NODES];
  logic [DIST_W-1:0] nd_d [NODES];
  logic [ROW_W-1:0]  nd_i [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < ROWS) begin : g_real
      assign nd_f[FIRST+j] = row_valid[j];
      assign nd_d[FIRST+j] = row_dist[j];
    end else begin : g_pad
      assign nd_f[FIRST+j] = 1'b0;
      assign nd_d[FIRST+j] = '0;
    end
    assign nd_i[FIRST+j] = ROW_W'(j);
  end

  // Left subtree always covers lower row indices; it keeps ties.
  for (genvar n = 0; n < FIRST; n++) begin : g_node
    logic pick_r;
    assign pick_r  = nd_f[2*n+2] && (!nd_f[2*n+1] || (nd_d[2*n+2] < nd_d[2*n+1]));
    assign nd_f[n] = nd_f[2*n+1] || nd_f[2*n+2];
    assign nd_d[n] = pick_r ? nd_d[2*n+2] : nd_d[2*n+1];
    assign nd_i[n] = pick_r ? nd_i[2*n+2] : nd_i[2*n+1];
  end

  assign win_found = nd_f[0];
  assign win_dist  = nd_d[0];
  assign win_idx   = nd_i[0];
endmodule

// File: rtl/hdc_phase_ctrl.sv
module hdc_phase_ctrl
  import hdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic accept,
  output logic load_dist,
  output logic capture,
  output logic done
);
  phase_e phase_q, phase_d;
  logic   done_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start) phase_d = PH_PRE;
      PH_PRE:  phase_d = PH_SRCH;
      PH_SRCH: phase_d = PH_EVAL;
      PH_EVAL: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= (phase_q == PH_EVAL);
    end
  end

  assign busy      = (phase_q != PH_IDLE);
  assign accept    = (phase_q == PH_IDLE) && start;
  assign load_dist = (phase_q == PH_SRCH);
  assign capture   = (phase_q == PH_EVAL);
  assign done      = done_q;
endmodule

// File: rtl/hdc_classifier.sv
module hdc_classifier #(
  parameter int VEC_W   = 128,
  parameter int ROWS    = 25,
  parameter int CLASS_W = 3,
  parameter int DIST_W  = 8,
  parameter int ROW_W   = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ROW_W-1:0]   wr_row,
  input  logic [CLASS_W-1:0] wr_class,
  input  logic               wr_valid,
  input  logic [VEC_W-1:0]   wr_data,
  input  logic               start,
  input  logic [VEC_W-1:0]   query,
  output logic               busy,
  output logic               done,
  output logic               res_found,
  output logic [CLASS_W-1:0] res_class,
  output logic [DIST_W-1:0]  res_dist
);
  logic               accept, load_dist, capture;
  logic [VEC_W-1:0]   query_q;
  logic [VEC_W-1:0]   row_data  [ROWS];
  logic [CLASS_W-1:0] row_class [ROWS];
  logic               row_valid [ROWS];
  logic [DIST_W-1:0]  row_dist  [ROWS];
  logic               win_found;
  logic [DIST_W-1:0]  win_dist;
  logic [ROW_W-1:0]   win_idx;
  logic               found_d;
  logic [CLASS_W-1:0] class_d;
  logic [DIST_W-1:0]  dist_d;

  hdc_phase_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .accept    (accept),
    .load_dist (load_dist),
    .capture   (capture),
    .done      (done)
  );

  hdc_template_bank #(
    .VEC_W(VEC_W), .ROWS(ROWS), .CLASS_W(CLASS_W), .ROW_W(ROW_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (busy),
    .wr_en     (wr_en),
    .wr_row    (wr_row),
    .wr_class  (wr_class),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .row_data  (row_data),
    .row_class (row_class),
    .row_valid (row_valid)
  );

  // Precharge phase: the query is captured once per search.
  always_ff @(posedge clk) begin
    if (accept) query_q <= query;
  end

  hdc_dist_array #(
    .VEC_W(VEC_W), .ROWS(ROWS), .DIST_W(DIST_W)
  ) u_dist (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_dist),
    .query_vec (query_q),
    .row_data  (row_data),
    .row_dist  (row_dist)
  );

  hdc_argmin_tree #(
    .ROWS(ROWS), .DIST_W(DIST_W), .ROW_W(ROW_W)
  ) u_tree (
    .row_valid (row_valid),
    .row_dist  (row_dist),
    .win_found (win_found),
    .win_dist  (win_dist),
    .win_idx   (win_idx)
  );

  always_comb begin
    found_d = win_found;
    class_d = '0;
    dist_d  = '0;
    if (win_found) begin
      dist_d = win_dist;
      for (int r = 0; r < ROWS; r++) begin
        if (win_idx == ROW_W'(r)) class_d = row_class[r];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_found <= 1'b0;
      res_class <= '0;
      res_dist  <= '0;
    end else if (capture) begin
      res_found <= found_d;
      res_class <= class_d;
      res_dist  <= dist_d;
    end
  end
endmodule

// File: rtl/hdc_classifier_chk.sv
module hdc_classifier_chk #(
  parameter int VEC_W   = 128,
  parameter int CLASS_W = 3,
  parameter int DIST_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               res_found,
  input logic [CLASS_W-1:0] res_class,
  input logic [DIST_W-1:0]  res_dist
);
  logic [2:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= (busy_run == 3'd7) ? busy_run : busy_run + 3'd1;
    else           busy_run <= '0;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < 3'd3));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_dist) && $stable(res_class) && $stable(res_found)));

  // R2
  dist_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_dist <= DIST_W'(VEC_W));

  // R5
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_found |-> (res_dist == '0 && res_class == '0));
endmodule

bind hdc_classifier hdc_classifier_chk #(
  .VEC_W(VEC_W), .CLASS_W(CLASS_W), .DIST_W(DIST_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .res_found (res_found),
  .res_class (res_class),
  .res_dist  (res_dist)
);

// File: tb/hdc_classifier_test.sv
module hdc_classifier_test;
  localparam int NR = 25;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en, wr_valid, start;
  logic [4:0]   wr_row;
  logic [2:0]   wr_class;
  logic [127:0] wr_data, query;
  logic         busy, done, res_found;
  logic [2:0]   res_class;
  logic [7:0]   res_dist;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [127:0] m_dat [NR];
  logic [2:0]   m_cls [NR];
  bit           m_vld [NR];

  always #5 clk = ~clk;

  hdc_classifier uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_class(wr_class), .wr_valid(wr_valid), .wr_data(wr_data),
    .start(start), .query(query), .busy(busy), .done(done),
    .res_found(res_found), .res_class(res_class), .res_dist(res_dist)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int hd(input logic [127:0] a, input logic [127:0] b);
    int c = 0;
    for (int i = 0; i < 128; i++) c += int'(a[i] ^ b[i]);
    return c;
  endfunction

  function automatic logic [127:0] rvec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] flip(input logic [127:0] v, input int n);
    logic [127:0] r = v;
    for (int k = 0; k < n; k++) r[$urandom % 128] ^= 1'b1;
    return r;
  endfunction

  // Write applied immediately (bench keeps writes in idle unless noted).
  task automatic write_row(input int row, input logic [127:0] d,
                           input logic [2:0] c, input bit v);
    wr_en = 1'b1; wr_row = 5'(row); wr_data = d; wr_class = c; wr_valid = v;
    tick();
    wr_en = 1'b0;
    if (row < NR) begin
      m_dat[row] = d; m_cls[row] = c; m_vld[row] = v;
    end
  endtask

  task automatic expect_of(input logic [127:0] q, output bit f,
                           output int c, output int d);
    f = 1'b0; c = 0; d = 0;
    for (int r = 0; r < NR; r++) begin
      if (m_vld[r] && (!f || hd(m_dat[r], q) < d)) begin
        f = 1'b1; d = hd(m_dat[r], q); c = int'(m_cls[r]);
      end
    end
  endtask

  task automatic search(input logic [127:0] q, input string req);
    bit ef; int ec, ed;
    expect_of(q, ef, ec, ed);
    start = 1'b1; query = q;
    tick();
    start = 1'b0; query = rvec();
    chk("R7 busy after accept", int'(busy), 1);
    chk("R7 no early done", int'(done), 0);
    tick(); tick();
    chk("R7 busy in evaluate", int'(busy), 1);
    tick();
    chk("R7 done pulse", int'(done), 1);
    chk("R7 busy released", int'(busy), 0);
    chk({req, " found"}, int'(res_found), int'(ef));
    chk({req, " class"}, int'(res_class), ec);
    chk({req, " dist"}, int'(res_dist), ed);
    tick();
    chk("R7 done single cycle", int'(done), 0);
    chk("R10 result held class", int'(res_class), ec);
    chk("R10 result held dist", int'(res_dist), ed);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, q;
    void'($urandom(32'h5EED_0071));
    rst_n = 1'b0; wr_en = 1'b0; start = 1'b0; wr_row = '0; wr_class = '0;
    wr_valid = 1'b0; wr_data = '0; query = '0;
    for (int r = 0; r < NR; r++) begin m_dat[r] = '0; m_cls[r] = '0; m_vld[r] = 1'b0; end
    tick(); tick();
    // R11 reset state
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 found", int'(res_found), 0);
    chk("R11 class", int'(res_class), 0);
    chk("R11 dist", int'(res_dist), 0);
    rst_n = 1'b1;
    tick();

    // R5 empty bank; R1 rows start invalid
    search(rvec(), "R5 R1 empty bank");

    // R3 one-shot: one row per class
    for (int c = 0; c < 5; c++) write_row(c, rvec(), 3'(c), 1'b1);
    search(flip(m_dat[3], 5), "R3 one-shot");
    search(~m_dat[2], "R2 far query");
    search(m_dat[4], "R6 exact match");
    // R2 distance of 128 only when every row is complement
    for (int r = 0; r < NR; r++) write_row(r, '0, 3'd0, 1'b0);
    write_row(7, '1, 3'd2, 1'b1);
    search('0, "R2 full distance 128");

    // R4 ties: identical templates, lower row wins
    a = rvec();
    write_row(9, a, 3'd1, 1'b1);
    write_row(3, a, 3'd4, 1'b1);
    search(flip(a, 3), "R4 tie lower row");
    // R5 invalidate the lower row, higher one must win
    write_row(3, a, 3'd4, 1'b0);
    search(a, "R5 invalid excluded");

    // R1 out-of-range row ignored
    b = rvec();
    write_row(27, b, 3'd3, 1'b1);
    search(b, "R1 out of range ignored");

    // R8 start during busy ignored
    start = 1'b1; query = a;
    tick();
    chk("R8 accepted", int'(busy), 1);
    tick(); tick();
    start = 1'b0;
    tick();
    chk("R8 done once", int'(done), 1);
    tick();
    chk("R8 no second search busy", int'(busy), 0);
    chk("R8 no second done", int'(done), 0);
    tick(); tick();
    chk("R8 still idle", int'(busy), 0);

    // R9 write during busy is held
    q = rvec();
    begin
      bit ef; int ec, ed;
      expect_of(q, ef, ec, ed);
      start = 1'b1; query = q;
      tick();
      start = 1'b0;
      wr_en = 1'b1; wr_row = 5'd0; wr_data = q; wr_class = 3'd6; wr_valid = 1'b1;
      tick();
      wr_en = 1'b0;
      tick(); tick();
      chk("R9 done", int'(done), 1);
      chk("R9 held write unseen class", int'(res_class), ec);
      chk("R9 held write unseen dist", int'(res_dist), ed);
      tick();
    end
    m_dat[0] = q; m_cls[0] = 3'd6; m_vld[0] = 1'b1;
    search(q, "R9 held write applied");

    // R3 five-shot random: several rows per class
    for (int it = 0; it < 60; it++) begin
      if (it % 10 == 0) begin
        for (int r = 0; r < NR; r++)
          write_row(r, rvec(), 3'(r / 5), ($urandom % 8) != 0);
      end
      q = flip(m_dat[$urandom % NR], $urandom % 12);
      search(q, "R3 five-shot random");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule